// File: doc/BRIEF.md
# Stack-Addressed Floating Register File

This block is an eight-entry file of opaque 80-bit words. Software never names an entry by its physical slot. Every access names a position relative to a 3-bit top pointer. Position 0 (ST0) is always the entry the pointer selects, and position i is the slot `(top + i) mod 8`.

A controller issues one operation per clock through a 3-bit code. A push steps the pointer down and places a value in the new top slot. A pop steps the pointer up. The other operations are:

- a write to a relative destination;
- an exchange of ST0 with another position;
- a flag-conditioned copy of a position into ST0;
- bare pointer increment or decrement, which move no data.

Two independent relative read ports show the stored state combinationally. During any cycle they reflect the contents before the coming edge.

Top module: `fp_stack_regfile`

## Requirements
- R1: While `rst_n` is low the pointer is 0 and every entry reads as zero.
- R2: Read port A returns the entry at slot `(top + ra_idx) mod 8`, and port B returns the entry at slot `(top + rb_idx) mod 8`. Both ports are combinational and show the state before the next edge.
- R3: Op code 1 (push) sets the pointer to `top - 1 mod 8`, so 0 wraps to 7, and stores `wdata` in the new ST0. The old ST(k) then reads as ST(k+1).
- R4: Op code 2 (pop) sets the pointer to `top + 1 mod 8`, so 7 wraps to 0, and changes no entry. The old ST1 then reads as ST0.
- R5: Op code 3 (write) stores `wdata` at ST(idx) and leaves the pointer unchanged.
- R6: Op code 4 (exchange) swaps ST0 and ST(idx) in one edge without moving the pointer. `idx` = 1 is the default partner, and `idx` = 0 leaves the file unchanged.
- R7: Op code 5 (conditional move) copies ST(idx) into ST0 when the selected condition holds and changes nothing when it does not. The pointer never changes.
- R8: The condition is chosen by `cc_sel`:
  - 0 when zf=1;
  - 1 when zf=0;
  - 2 when cf=1;
  - 3 when cf=1 or zf=1;
  - 4 when cf=0;
  - 5 when cf=0 and zf=0;
  - 6 when pf=1;
  - 7 when pf=0.
- R9: Op code 6 adds 1 to the pointer and op code 7 subtracts 1, both mod 8. Neither changes any entry.
- R10: Op code 0 changes neither the pointer nor any entry. `idx`, `cc_sel`, the flags and `wdata` have no effect except under the op codes that use them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| op | input | 3 | Operation code (0 nop, 1 push, 2 pop, 3 write, 4 exchange, 5 conditional move, 6 increment, 7 decrement) |
| idx | input | 3 | Relative position used by write, exchange and conditional move |
| cc_sel | input | 3 | Condition selector for the conditional move |
| zf | input | 1 | Zero flag |
| cf | input | 1 | Carry flag |
| pf | input | 1 | Parity (unordered) flag |
| wdata | input | 80 | Value for push and write |
| ra_idx | input | 3 | Relative position for read port A |
| rb_idx | input | 3 | Relative position for read port B |
| ra_data | output | 80 | Entry at ST(ra_idx) |
| rb_data | output | 80 | Entry at ST(rb_idx) |
| top | output | 3 | Current top pointer |

## Verification
The bench drives the pointer across both wrap points with nine pushes and long pop runs. A design that saturated, or that wrote before decrementing, would then show a shifted or stale ST0.

It exchanges with position 0 and with high positions while the pointer is non-zero. This exposes a swap that indexes physical slots or loses one half of the swap.

Every one of the eight conditions is tried under all eight flag combinations. An inverted or swapped condition would copy when it should hold, or hold when it should copy.

Each cycle, all eight positions are read through both ports and compared with a behavioural model. This catches a write that lands on the wrong slot or a stray change made by nop, pop or the pointer-only operations.

// File: rtl/fp_stack_regfile.sv
module fp_stack_regfile #(
  parameter int W     = 80,
  parameter int DEPTH = 8,
  localparam int PW   = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [2:0]    op,
  input  logic [PW-1:0] idx,
  input  logic [2:0]    cc_sel,
  input  logic          zf,
  input  logic          cf,
  input  logic          pf,
  input  logic [W-1:0]  wdata,
  input  logic [PW-1:0] ra_idx,
  input  logic [PW-1:0] rb_idx,
  output logic [W-1:0]  ra_data,
  output logic [W-1:0]  rb_data,
  output logic [PW-1:0] top
);

  localparam logic [2:0] OP_NOP   = 3'd0;
  localparam logic [2:0] OP_PUSH  = 3'd1;
  localparam logic [2:0] OP_POP   = 3'd2;
  localparam logic [2:0] OP_WRITE = 3'd3;
  localparam logic [2:0] OP_XCHG  = 3'd4;
  localparam logic [2:0] OP_CMOV  = 3'd5;
  localparam logic [2:0] OP_INC   = 3'd6;
  localparam logic [2:0] OP_DEC   = 3'd7;
  localparam logic [PW-1:0] ONE   = PW'(1);

  logic [W-1:0]  regs [DEPTH];
  logic [PW-1:0] tos;
  logic [PW-1:0] tgt, up, dn;
  logic          take;

  assign tgt = tos + idx;
  assign up  = tos + ONE;
  assign dn  = tos - ONE;

  assign ra_data = regs[tos + ra_idx];
  assign rb_data = regs[tos + rb_idx];
  assign top     = tos;

  always_comb begin
    case (cc_sel)
      3'd0:    take = zf;
      3'd1:    take = !zf;
      3'd2:    take = cf;
      3'd3:    take = cf | zf;
      3'd4:    take = !cf;
      3'd5:    take = !cf & !zf;
      3'd6:    take = pf;
      default: take = !pf;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tos <= '0;
      for (int k = 0; k < DEPTH; k++) regs[k] <= '0;
    end else begin
      case (op)
        OP_PUSH: begin
          tos       <= dn;
          regs[dn]  <= wdata;
        end
        OP_POP:   tos <= up;
        OP_WRITE: regs[tgt] <= wdata;
        OP_XCHG: begin
          regs[tos] <= regs[tgt];
          regs[tgt] <= regs[tos];
        end
        OP_CMOV:  if (take) regs[tos] <= regs[tgt];
        OP_INC:   tos <= up;
        OP_DEC:   tos <= dn;
        OP_NOP:   ;
        default:  ;
      endcase
    end
  end

endmodule

// File: rtl/fp_stack_regfile_chk.sv
module fp_stack_regfile_chk #(
  parameter int W     = 80,
  parameter int DEPTH = 8,
  localparam int PW   = $clog2(DEPTH)
) (
  input logic          clk,
  input logic          rst_n,
  input logic [2:0]    op,
  input logic [PW-1:0] idx,
  input logic [2:0]    cc_sel,
  input logic          zf,
  input logic          cf,
  input logic          pf,
  input logic [W-1:0]  wdata,
  input logic [PW-1:0] top,
  input logic [W-1:0]  regs [DEPTH]
);

  localparam logic [PW-1:0] ONE = PW'(1);

  logic [PW-1:0] slot;
  logic          hit;

  assign slot = top + idx;
  assign hit  = (cc_sel == 3'd0 && zf) || (cc_sel == 3'd1 && !zf) ||
                (cc_sel == 3'd2 && cf) || (cc_sel == 3'd3 && (cf || zf)) ||
                (cc_sel == 3'd4 && !cf) || (cc_sel == 3'd5 && !cf && !zf) ||
                (cc_sel == 3'd6 && pf) || (cc_sel == 3'd7 && !pf);

  // R3
  push_dec_chk: assert property (@(posedge clk) disable iff (!rst_n)
    op == 3'd1 |=> top == $past(top) - ONE);

  // R3
  push_data_chk: assert property (@(posedge clk) disable iff (!rst_n)
    op == 3'd1 |=> regs[top] == $past(wdata));

  // R4
  pop_inc_chk: assert property (@(posedge clk) disable iff (!rst_n)
    op == 3'd2 |=> top == $past(top) + ONE);

  // R9
  inc_ptr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    op == 3'd6 |=> top == $past(top) + ONE);

  // R9
  dec_ptr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    op == 3'd7 |=> top == $past(top) - ONE);

  // R5
  write_data_chk: assert property (@(posedge clk) disable iff (!rst_n)
    op == 3'd3 |=> regs[$past(slot)] == $past(wdata) && $stable(top));

  // R6
  xchg_top_chk: assert property (@(posedge clk) disable iff (!rst_n)
    op == 3'd4 |=> regs[top] == $past(regs[slot]) && $stable(top));

  // R7
  cmov_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    op == 3'd5 && !hit |=> regs[top] == $past(regs[top]) && $stable(top));

  // R8
  cmov_take_chk: assert property (@(posedge clk) disable iff (!rst_n)
    op == 3'd5 && hit |=> regs[top] == $past(regs[slot]) && $stable(top));

  // R10
  nop_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    op == 3'd0 |=> $stable(top) && regs[top] == $past(regs[top]));

endmodule

bind fp_stack_regfile fp_stack_regfile_chk #(.W(W), .DEPTH(DEPTH)) u_chk (
  .clk(clk), .rst_n(rst_n), .op(op), .idx(idx), .cc_sel(cc_sel),
  .zf(zf), .cf(cf), .pf(pf), .wdata(wdata), .top(tos), .regs(regs)
);

// File: tb/fp_stack_regfile_bench.sv
module fp_stack_regfile_bench;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [2:0]  op = 3'd0;
  logic [2:0]  idx = 3'd0;
  logic [2:0]  cc_sel = 3'd0;
  logic        zf = 1'b0, cf = 1'b0, pf = 1'b0;
  logic [79:0] wdata = '0;
  logic [2:0]  ra_idx = 3'd0, rb_idx = 3'd0;
  logic [79:0] ra_data, rb_data;
  logic [2:0]  top;

  int tests = 0;
  int fails = 0;
  bit done  = 1'b0;

  logic [79:0] m [8];
  int mt;

  always #10 clk = ~clk;

  fp_stack_regfile u_fp_stack_regfile (
    .clk(clk), .rst_n(rst_n), .op(op), .idx(idx), .cc_sel(cc_sel),
    .zf(zf), .cf(cf), .pf(pf), .wdata(wdata), .ra_idx(ra_idx),
    .rb_idx(rb_idx), .ra_data(ra_data), .rb_data(rb_data), .top(top)
  );

  function automatic bit cond_ok(int c, bit z, bit cy, bit p);
    case (c)
      0: return z;
      1: return !z;
      2: return cy;
      3: return cy || z;
      4: return !cy;
      5: return !cy && !z;
      6: return p;
      default: return !p;
    endcase
  endfunction

  function automatic logic [79:0] rnd80();
    return {16'($urandom), $urandom, $urandom};
  endfunction

  task automatic check_state(input string tag);
    tests++;
    if (top !== 3'(mt)) begin
      fails++;
      $display("FAIL %s top: actual %0d expected %0d", tag, top, mt);
    end
    for (int k = 0; k < 8; k++) begin
      ra_idx = 3'(k);
      rb_idx = 3'(7 - k);
      #1;
      tests++;
      if (ra_data !== m[(mt + k) % 8] || rb_data !== m[(mt + 7 - k) % 8]) begin
        fails++;
        $display("FAIL %s R2 ST%0d: actual %h/%h expected %h/%h", tag, k,
                 ra_data, rb_data, m[(mt + k) % 8], m[(mt + 7 - k) % 8]);
      end
    end
  endtask

  task automatic step(input int o, input int i, input int c, input bit z,
                      input bit cy, input bit p, input logic [79:0] d,
                      input string tag);
    int s;
    logic [79:0] t;
    op = 3'(o); idx = 3'(i); cc_sel = 3'(c);
    zf = z; cf = cy; pf = p; wdata = d;
    @(posedge clk);
    s = (mt + i) % 8;
    case (o)
      1: begin mt = (mt + 7) % 8; m[mt] = d; end
      2: mt = (mt + 1) % 8;
      3: m[s] = d;
      4: begin t = m[mt]; m[mt] = m[s]; m[s] = t; end
      5: if (cond_ok(c, z, cy, p)) m[mt] = m[s];
      6: mt = (mt + 1) % 8;
      7: mt = (mt + 7) % 8;
      default: ;
    endcase
    #1;
    op = 3'd0; idx = 3'(~i); wdata = rnd80();
    @(negedge clk);
    check_state(tag);
  endtask

  task automatic expect_val(input int pos, input logic [79:0] e, input string tag);
    ra_idx = 3'(pos);
    #1;
    tests++;
    if (ra_data !== e) begin
      fails++;
      $display("FAIL %s ST%0d: actual %h expected %h", tag, pos, ra_data, e);
    end
  endtask

  initial begin
    for (int k = 0; k < 8; k++) m[k] = '0;
    mt = 0;
    @(negedge clk);
    check_state("R1");
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check_state("R1");

    // R3: push wraps 0 -> 7, nine pushes overwrite the oldest slot
    for (int k = 0; k < 9; k++) step(1, 0, 0, 0, 0, 0, 80'h1000 + 80'(k), "R3");
    expect_val(0, 80'h1008, "R3");
    expect_val(1, 80'h1007, "R3");
    expect_val(7, 80'h1001, "R3");

    // R4: pop across the 7 -> 0 wrap
    for (int k = 0; k < 10; k++) step(2, 0, 0, 0, 0, 0, rnd80(), "R4");

    // R5: write at every relative position
    for (int k = 0; k < 8; k++) step(3, k, 0, 0, 0, 0, 80'hA0 + 80'(k), "R5");
    expect_val(3, 80'hA3, "R5");

    // R6: default partner, self, and far positions
    step(4, 1, 0, 0, 0, 0, '0, "R6");
    expect_val(0, 80'hA1, "R6");
    expect_val(1, 80'hA0, "R6");
    step(4, 0, 0, 0, 0, 0, '0, "R6");
    step(4, 6, 0, 0, 0, 0, '0, "R6");
    step(4, 7, 0, 0, 0, 0, '0, "R6");

    // R7 / R8: every condition under every flag set
    for (int c = 0; c < 8; c++)
      for (int f = 0; f < 8; f++) begin
        step(3, (c + f) % 7 + 1, 0, 0, 0, 0, rnd80(), "R7");
        step(5, (c + f) % 7 + 1, c, f[0], f[1], f[2], rnd80(), "R8");
      end

    // R9: pointer-only moves across both wraps
    for (int k = 0; k < 9; k++) step(6, k % 8, 0, 0, 0, 0, rnd80(), "R9");
    for (int k = 0; k < 10; k++) step(7, k % 8, 0, 0, 0, 0, rnd80(), "R9");

    // R10: nop with busy side inputs
    for (int k = 0; k < 4; k++) step(0, k, k, 1, 1, 1, rnd80(), "R10");

    // mixed traffic
    for (int k = 0; k < 400; k++) begin
      int o;
      o = int'($urandom % 8);
      step(o, int'($urandom % 8), int'($urandom % 8), 1'($urandom), 1'($urandom),
           1'($urandom), rnd80(), $sformatf("R%0d", o == 0 ? 10 : o == 1 ? 3 :
           o == 2 ? 4 : o == 3 ? 5 : o == 4 ? 6 : o == 5 ? 7 : 9));
    end

    if (!done) begin
      done = 1'b1;
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    #(200000 * 20);
    if (!done) begin
      done = 1'b1;
      tests++;
      fails++;
      $display("FAIL watchdog expired: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

endmodule